// File: doc/BRIEF.md
# Cascaded Four-Cell Decimating FIR Engine

This block is a systolic FIR datapath. Four filter cells each hold one multiplier and one wide accumulator. Every clock in which data is enabled, each cell multiplies its own coefficient by the sample in front of it and adds the product into its accumulator. The four cells together therefore complete four multiply-accumulates per sample period.

Coefficients move through the cells in a chain. The last cell's coefficient leaves on a cascade port, so several engines can be linked. Samples move through the cells along a delay line whose length per cell is selectable, and this reduces the output rate by 1, 2, 3 or 4.

An output stage reads one cell accumulator through a multiplexer. It either loads that value, or adds it to its own previous value shifted right by eight bits. A result wider than one pass can be built this way from byte-sized partial products. Coefficients and samples are each read as unsigned or as two's complement under their own control.

Top module: `decfir_engine`

## Requirements
- R1: `rst` is a synchronous reset, active high. It clears every register: after a clock with `rst` high, `result` is 0 and `coef_out` is 0.
- R2: `din_en_n` is active low. While it is high, the sample input register, every delay line and every accumulator keep their values, except for an accumulator being erased. While `cin_en_n` is high, the coefficient input register and the whole coefficient chain keep their values.
- R3: Each clock with `cin_en_n` low loads `cin` into the coefficient input register. In the same clock, the chain shifts by one: input register to cell 0, then cell 0 to cell 1, and so on. `coef_out` is the coefficient of cell 3, so it shows a `cin` value five enabled clocks after that value was presented.
- R4: Each operand is extended to 9 bits before the multiply: by sign when its mode bit is 1, by zero when it is 0. `coef_sgn` controls the coefficient and `data_sgn` controls the sample. The 18-bit signed product is then sign-extended to the accumulator width. Example: operands 0xFF, 0xFF give 65025 unsigned/unsigned, 1 signed/signed, and -255 in either mixed case.
- R5: Accumulators and the output accumulator wrap modulo 2^26.
- R6: Cell 0 takes its sample from the input register. Cell k+1 takes its sample from cell k delayed by `dec_mode`+1 enabled clocks. Encoding: 0 → 1 clock, 1 → 2, 2 → 3, 3 → 4. The same delay applies between every pair of neighbouring cells.
- R7: With `erase` high, the accumulator of the cell addressed by `acc_sel` becomes 0 at the next clock. This holds even when data is enabled, and no other cell is affected.
- R8: `acc_sel` (0..3) picks which cell accumulator feeds the output stage.
- R9: At each clock the output accumulator takes the selected cell value when `shadd` is 0. When `shadd` is 1, it takes that value plus its own previous value shifted right by 8 bits with zero fill.
- R10: The result register takes the output accumulator one clock later, so `result` trails the output accumulator by one cycle. `result` shows the result register while `res_oe` is 1 and 0 while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | Sample input |
| din_en_n | input | 1 | Sample enable, active low |
| cin | input | 8 | Coefficient input |
| cin_en_n | input | 1 | Coefficient enable, active low |
| data_sgn | input | 1 | 1: samples are two's complement |
| coef_sgn | input | 1 | 1: coefficients are two's complement |
| dec_mode | input | 2 | Inter-cell sample delay minus one |
| erase | input | 1 | Clear the addressed cell accumulator |
| acc_sel | input | 2 | Cell accumulator address |
| shadd | input | 1 | 1: add shifted output accumulator, 0: load |
| res_oe | input | 1 | Result output enable |
| result | output | 26 | Gated result register |
| coef_out | output | 8 | Cascade coefficient from cell 3 |

## Verification
The bench builds the engine with its default parameters: four cells, three decimation registers per cell, 8-bit operands and 26-bit accumulators. With these values, a stream of full-scale unsigned products (65025 each) passes 2^26 after about 1032 samples. This puts the wrap of R5 within a run of roughly a thousand cycles. The two-bit mode and address fields also reach every delay setting and every cell.

// File: rtl/decfir_pkg.sv
`timescale 1ns/1ps
package decfir_pkg;
    localparam int SAMP_W    = 8;
    localparam int COEF_W    = 8;
    localparam int ACC_W     = 26;
    localparam int N_CELLS   = 4;
    localparam int DEC_REGS  = 3;
    localparam int OUT_SHIFT = 8;

    typedef enum logic [1:0] {
        DEC_BY_1 = 2'd0,
        DEC_BY_2 = 2'd1,
        DEC_BY_3 = 2'd2,
        DEC_BY_4 = 2'd3
    } dec_mode_e;
endpackage

// File: rtl/decfir_mult.sv
`timescale 1ns/1ps
// Mixed-signedness multiplier: each operand is widened by one bit
// (sign or zero), multiplied signed, then sign-extended to PW bits.
module decfir_mult #(
    parameter int AW = 8,
    parameter int BW = 8,
    parameter int PW = 26
) (
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    input  logic          a_sgn,
    input  logic          b_sgn,
    output logic [PW-1:0] p
);
    localparam int PRW = AW + BW + 2;

    logic signed [AW:0]    ax;
    logic signed [BW:0]    bx;
    logic signed [PRW-1:0] pr;

    assign ax = $signed({a_sgn & a[AW-1], a});
    assign bx = $signed({b_sgn & b[BW-1], b});
    assign pr = ax * bx;

    generate
        if (PW > PRW) begin : g_ext
            assign p = {{(PW-PRW){pr[PRW-1]}}, pr};
        end else begin : g_trunc
            assign p = pr[PW-1:0];
        end
    endgenerate
endmodule

// File: rtl/decfir_cell.sv
`timescale 1ns/1ps
// One filter cell: coefficient stage, selectable-length sample delay,
// multiplier and accumulator.
module decfir_cell #(
    parameter int SW       = 8,
    parameter int CW       = 8,
    parameter int AW       = 26,
    parameter int DEC_REGS = 3
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                samp_en,
    input  logic                                coef_en,
    input  logic                                clr,
    input  logic                                data_sgn,
    input  logic                                coef_sgn,
    input  logic [$clog2(DEC_REGS+1)-1:0]       dec_sel,
    input  logic [SW-1:0]                       samp_in,
    input  logic [CW-1:0]                       coef_in,
    output logic [SW-1:0]                       samp_out,
    output logic [CW-1:0]                       coef_out,
    output logic [AW-1:0]                       acc_out
);
    localparam int NTAP = DEC_REGS + 1;

    typedef struct packed {
        logic [CW-1:0]            coef;
        logic [NTAP-1:0][SW-1:0]  dl;
        logic [AW-1:0]            acc;
    } cell_st_t;

    cell_st_t      st_d, st_q;
    logic [AW-1:0] prod;

    decfir_mult #(.AW(CW), .BW(SW), .PW(AW)) u_mult (
        .a     (st_q.coef),
        .b     (samp_in),
        .a_sgn (coef_sgn),
        .b_sgn (data_sgn),
        .p     (prod)
    );

    always_comb begin
        st_d = st_q;
        if (coef_en) begin
            st_d.coef = coef_in;
        end
        if (samp_en) begin
            st_d.dl[0] = samp_in;
            for (int i = 1; i < NTAP; i++) begin
                st_d.dl[i] = st_q.dl[i-1];
            end
            st_d.acc = st_q.acc + prod;
        end
        if (clr) begin
            st_d.acc = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign samp_out = st_q.dl[dec_sel];
    assign coef_out = st_q.coef;
    assign acc_out  = st_q.acc;

    // R2: an idle, un-erased accumulator keeps its sum
    p_acc_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!samp_en && !clr) |=> $stable(st_q.acc));

    // R3: the coefficient stage moves only when coefficients are enabled
    p_coef_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !coef_en |=> $stable(st_q.coef));

    // R7: erase wins over accumulation
    p_erase_r7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_out == '0));
endmodule

// File: rtl/decfir_out_stage.sv
`timescale 1ns/1ps
// Output multiplexer, shift-and-add accumulator and result register.
module decfir_out_stage #(
    parameter int AW = 26,
    parameter int N  = 4,
    parameter int SH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N-1:0][AW-1:0]     acc_in,
    input  logic [$clog2(N)-1:0]     sel,
    input  logic                     shadd,
    input  logic                     oe,
    output logic [AW-1:0]            result
);
    typedef struct packed {
        logic [AW-1:0] oacc;
        logic [AW-1:0] res;
    } out_st_t;

    out_st_t       st_d, st_q;
    logic [AW-1:0] pick;

    assign pick = acc_in[sel];

    always_comb begin
        st_d = st_q;
        if (shadd) begin
            st_d.oacc = pick + (st_q.oacc >> SH);
        end else begin
            st_d.oacc = pick;
        end
        st_d.res = st_q.oacc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result = oe ? st_q.res : '0;

    // R9: in load mode the output accumulator takes the selected cell value
    p_load_r9: assert property (@(posedge clk) disable iff (rst)
        !shadd |=> (st_q.oacc == $past(acc_in[sel])));
endmodule

// File: rtl/decfir_engine.sv
`timescale 1ns/1ps
module decfir_engine
    import decfir_pkg::*;
#(
    parameter int SAMP_W    = decfir_pkg::SAMP_W,
    parameter int COEF_W    = decfir_pkg::COEF_W,
    parameter int ACC_W     = decfir_pkg::ACC_W,
    parameter int N_CELLS   = decfir_pkg::N_CELLS,
    parameter int DEC_REGS  = decfir_pkg::DEC_REGS,
    parameter int OUT_SHIFT = decfir_pkg::OUT_SHIFT
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [SAMP_W-1:0]              din,
    input  logic                           din_en_n,
    input  logic [COEF_W-1:0]              cin,
    input  logic                           cin_en_n,
    input  logic                           data_sgn,
    input  logic                           coef_sgn,
    input  logic [$clog2(DEC_REGS+1)-1:0]  dec_mode,
    input  logic                           erase,
    input  logic [$clog2(N_CELLS)-1:0]     acc_sel,
    input  logic                           shadd,
    input  logic                           res_oe,
    output logic [ACC_W-1:0]               result,
    output logic [COEF_W-1:0]              coef_out
);
    localparam int SEL_W = $clog2(N_CELLS);

    typedef struct packed {
        logic [SAMP_W-1:0] x;
        logic [COEF_W-1:0] c;
    } in_st_t;

    in_st_t in_d, in_q;
    logic   samp_en, coef_en;

    logic [N_CELLS-1:0][SAMP_W-1:0] samp_chain;
    logic [N_CELLS-1:0][COEF_W-1:0] coef_chain;
    logic [N_CELLS-1:0][ACC_W-1:0]  acc_bus;
    logic [N_CELLS-1:0]             clr_vec;

    assign samp_en = !din_en_n;
    assign coef_en = !cin_en_n;

    always_comb begin
        in_d = in_q;
        if (samp_en) in_d.x = din;
        if (coef_en) in_d.c = cin;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q <= '0;
        end else begin
            in_q <= in_d;
        end
    end

    generate
        for (genvar k = 0; k < N_CELLS; k++) begin : gen_cell
            logic [SAMP_W-1:0] s_in;
            logic [COEF_W-1:0] c_in;

            if (k == 0) begin : g_head
                assign s_in = in_q.x;
                assign c_in = in_q.c;
            end else begin : g_link
                assign s_in = samp_chain[k-1];
                assign c_in = coef_chain[k-1];
            end

            assign clr_vec[k] = erase && (acc_sel == SEL_W'(k));

            decfir_cell #(
                .SW(SAMP_W), .CW(COEF_W), .AW(ACC_W), .DEC_REGS(DEC_REGS)
            ) u_cell (
                .clk      (clk),
                .rst      (rst),
                .samp_en  (samp_en),
                .coef_en  (coef_en),
                .clr      (clr_vec[k]),
                .data_sgn (data_sgn),
                .coef_sgn (coef_sgn),
                .dec_sel  (dec_mode),
                .samp_in  (s_in),
                .coef_in  (c_in),
                .samp_out (samp_chain[k]),
                .coef_out (coef_chain[k]),
                .acc_out  (acc_bus[k])
            );
        end
    endgenerate

    decfir_out_stage #(.AW(ACC_W), .N(N_CELLS), .SH(OUT_SHIFT)) u_out (
        .clk    (clk),
        .rst    (rst),
        .acc_in (acc_bus),
        .sel    (acc_sel),
        .shadd  (shadd),
        .oe     (res_oe),
        .result (result)
    );

    assign coef_out = coef_chain[N_CELLS-1];

    // R7: an erase never reaches more than one cell
    p_erase_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_vec));

    // R3: the cascade output moves only after an enabled coefficient clock
    p_cout_stable_r3: assert property (@(posedge clk) disable iff (rst)
        !coef_en |=> $stable(coef_out));
endmodule

// File: tb/decfir_engine_tb_top.sv
`timescale 1ns/1ps
module decfir_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  din;
    logic        din_en_n;
    logic [7:0]  cin;
    logic        cin_en_n;
    logic        data_sgn, coef_sgn;
    logic [1:0]  dec_mode;
    logic        erase;
    logic [1:0]  acc_sel;
    logic        shadd;
    logic        res_oe;
    logic [25:0] result;
    logic [7:0]  coef_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    decfir_engine dut_i (
        .clk(clk), .rst(rst), .din(din), .din_en_n(din_en_n),
        .cin(cin), .cin_en_n(cin_en_n), .data_sgn(data_sgn),
        .coef_sgn(coef_sgn), .dec_mode(dec_mode), .erase(erase),
        .acc_sel(acc_sel), .shadd(shadd), .res_oe(res_oe),
        .result(result), .coef_out(coef_out)
    );

    // reference state, built from the requirements
    logic [7:0]  m_x, m_c;
    logic [7:0]  m_coef [4];
    logic [7:0]  m_dl   [4][4];
    logic [25:0] m_acc  [4];
    logic [25:0] m_oacc, m_res;

    logic [25:0] q_res [$];
    logic [7:0]  q_co  [$];
    string       q_tag [$];

    function automatic logic [25:0] mulx(logic [7:0] c, logic [7:0] x, bit cs, bit ds);
        int a, b, p;
        a = cs ? int'($signed(c)) : int'(c);
        b = ds ? int'($signed(x)) : int'(x);
        p = a * b;
        return p[25:0];
    endfunction

    task automatic model_reset();
        m_x = '0; m_c = '0; m_oacc = '0; m_res = '0;
        for (int k = 0; k < 4; k++) begin
            m_coef[k] = '0; m_acc[k] = '0;
            for (int j = 0; j < 4; j++) m_dl[k][j] = '0;
        end
    endtask

    // driver: inputs are already set; advance the model across the coming edge
    task automatic step(string tag);
        logic [7:0]  n_coef [4];
        logic [7:0]  n_dl   [4][4];
        logic [25:0] n_acc  [4];
        logic [7:0]  s_in   [4];
        logic [7:0]  n_x, n_c;
        logic [25:0] n_oacc, n_res;
        if (rst) begin
            model_reset();
        end else begin
            for (int k = 0; k < 4; k++) begin
                s_in[k] = (k == 0) ? m_x : m_dl[k-1][dec_mode];
                n_coef[k] = m_coef[k];
                n_acc[k]  = m_acc[k];
                for (int j = 0; j < 4; j++) n_dl[k][j] = m_dl[k][j];
            end
            n_x = m_x; n_c = m_c;
            if (!cin_en_n) begin
                n_c = cin;
                n_coef[0] = m_c;
                for (int k = 1; k < 4; k++) n_coef[k] = m_coef[k-1];
            end
            if (!din_en_n) begin
                n_x = din;
                for (int k = 0; k < 4; k++) begin
                    n_dl[k][0] = s_in[k];
                    for (int j = 1; j < 4; j++) n_dl[k][j] = m_dl[k][j-1];
                    n_acc[k] = m_acc[k] + mulx(m_coef[k], s_in[k], coef_sgn, data_sgn);
                end
            end
            if (erase) n_acc[acc_sel] = '0;
            n_oacc = shadd ? (m_acc[acc_sel] + (m_oacc >> 8)) : m_acc[acc_sel];
            n_res  = m_oacc;
            m_x = n_x; m_c = n_c; m_oacc = n_oacc; m_res = n_res;
            for (int k = 0; k < 4; k++) begin
                m_coef[k] = n_coef[k]; m_acc[k] = n_acc[k];
                for (int j = 0; j < 4; j++) m_dl[k][j] = n_dl[k][j];
            end
        end
        q_res.push_back(res_oe ? m_res : 26'd0);
        q_co.push_back(m_coef[3]);
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    // monitor: compare one expected item after every edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_res.size() > 0) begin
                logic [25:0] er;
                logic [7:0]  ec;
                string       tg;
                er = q_res.pop_front();
                ec = q_co.pop_front();
                tg = q_tag.pop_front();
                checks++;
                if (result !== er || coef_out !== ec) begin
                    errors++;
                    $display("FAIL %s: result=%h coef_out=%h expected result=%h coef_out=%h",
                             tg, result, coef_out, er, ec);
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic load_coef(logic [7:0] v, string tag);
        cin = v; cin_en_n = 1'b0;
        step(tag);
        cin_en_n = 1'b1;
    endtask

    task automatic erase_all(string tag);
        din_en_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            erase = 1'b1; acc_sel = 2'(k);
            step(tag);
        end
        erase = 1'b0;
    endtask

    initial begin
        rst = 1'b1; din = 8'hA5; din_en_n = 1'b0; cin = 8'h3C; cin_en_n = 1'b0;
        data_sgn = 0; coef_sgn = 0; dec_mode = 2'd0; erase = 0; acc_sel = 2'd0;
        shadd = 0; res_oe = 1;
        model_reset();
        @(negedge clk);
        for (int i = 0; i < 3; i++) step("R1 reset");
        rst = 1'b0;

        // R3: coefficient ripple with data idle; R2 accumulators stay 0
        din_en_n = 1'b1;
        for (int i = 0; i < 8; i++) load_coef(8'(i + 1), "R3 coef chain");
        for (int i = 0; i < 4; i++) begin
            cin = 8'($urandom);
            step("R2 coef hold");
        end

        // R4/R8: random coefficients and samples in every sign mode
        for (int i = 0; i < 5; i++) load_coef(8'($urandom), "R3 coef load");
        erase_all("R7 erase");
        for (int m = 0; m < 4; m++) begin
            coef_sgn = m[1]; data_sgn = m[0];
            din_en_n = 1'b0;
            for (int i = 0; i < 12; i++) begin
                din = 8'($urandom); acc_sel = 2'(i % 4);
                step("R4 R8 mixed signs");
            end
        end

        // R4: full-scale 0xFF operands
        for (int i = 0; i < 5; i++) load_coef(8'hFF, "R3 coef load");
        for (int m = 0; m < 4; m++) begin
            erase_all("R7 erase");
            coef_sgn = m[1]; data_sgn = m[0];
            din = 8'hFF; din_en_n = 1'b0;
            for (int i = 0; i < 8; i++) begin
                acc_sel = 2'(i % 4);
                step("R4 full scale");
            end
        end

        // R2: data idle while the input changes
        din_en_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            din = 8'($urandom); acc_sel = 2'(i % 4);
            step("R2 data hold");
        end

        // R9: multi-pass shift-and-add
        for (int i = 0; i < 10; i++) begin
            acc_sel = 2'(i % 4); shadd = (i % 5) != 0;
            step("R9 shift add");
        end
        shadd = 1'b0;

        // R10: output enable gating
        res_oe = 1'b0;
        for (int i = 0; i < 6; i++) begin
            acc_sel = 2'(i % 4);
            step("R10 oe low");
        end
        res_oe = 1'b1;
        for (int i = 0; i < 4; i++) step("R10 oe high");

        // R6: impulse through each decimation mode
        coef_sgn = 0; data_sgn = 0;
        for (int i = 0; i < 5; i++) load_coef(8'(i + 1), "R3 coef load");
        for (int m = 0; m < 4; m++) begin
            dec_mode = 2'(m);
            din = 8'h00; din_en_n = 1'b0;
            for (int i = 0; i < 20; i++) step("R6 flush");
            erase_all("R7 erase");
            din = 8'h01; din_en_n = 1'b0;
            step("R6 impulse");
            din = 8'h00;
            for (int i = 0; i < 24; i++) begin
                acc_sel = 2'(i % 4);
                step("R6 decimation");
            end
        end

        // R7: erase one cell while data is enabled
        din = 8'h07; din_en_n = 1'b0; erase = 1'b1; acc_sel = 2'd2;
        step("R7 erase priority");
        erase = 1'b0; din_en_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            acc_sel = 2'(i % 4);
            step("R7 others kept");
        end

        // R5: full-scale unsigned products past 2^26
        dec_mode = 2'd0;
        for (int i = 0; i < 5; i++) load_coef(8'hFF, "R3 coef load");
        erase_all("R7 erase");
        din = 8'hFF; din_en_n = 1'b0; acc_sel = 2'd0;
        for (int i = 0; i < 1100; i++) step("R5 wrap");
        din_en_n = 1'b1;
        for (int i = 0; i < 3; i++) step("R5 wrap settle");

        @(posedge clk);
        #2;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule